// File: doc/BRIEF.md
# Banked GPIO Port with Per-Pin Function Codes

This block is a memory-mapped port for 54 general-purpose pins. The pins are grouped into two banks of 32 bits and are reached over a plain 32-bit register bus. Every pin carries a 3-bit function code. The code makes the pin a software input or a software output, or hands the pin to one of six alternate peripherals. Each code leaves the block on its own field, so that an external mux can route the alternate peripheral.

Software drives the output latches only through write-one-to-set and write-one-to-clear words. Zero bits in those words change nothing, so software never needs a read-modify-write to change one pin. Pin inputs pass through a two-flop synchroniser. Software then reads them one bit per pin through a level word for each bank.

The bus is a single-cycle strobe (`bus_sel` with `bus_wr`) on a byte address. The low two address bits must be zero for a word to decode. Read data is registered and appears on `bus_rdata` in the cycle after the read strobe.

Top module: `gpio_fsel_port`

## Requirements
- R1: After reset every function code is 0, every output latch is 0, `pin_oe` and `pin_func` are all zero, and every function word reads 0.
- R2: Function words sit at byte offsets 0x00, 0x04, ... 0x14, one word for every ten pins. Pin p uses word p/10, bits [(p mod 10)*3 +: 3]. Bits 31:30 of each word read as 0. In the word at 0x14 only bits 11:0 (pins 50 to 53) are kept.
- R3: The set words are at 0x1C (pins 0 to 31) and 0x20 (pins 32 to 53, at bits 0 to 21). A 1 bit sets that pin's output latch. A 0 bit leaves it unchanged.
- R4: The clear words are at 0x28 and 0x2C, with the same bit layout as the set words. A 1 bit clears that pin's output latch. A 0 bit leaves it unchanged.
- R5: `pin_oe[p]` is high exactly while pin p's code is 1. Code 0 and the alternate codes (4, 5, 6 and 7 are alternates 0 to 3, 3 is alternate 4, 2 is alternate 5) keep it low. `pin_func[p*3 +: 3]` carries pin p's code.
- R6: The level words at 0x34 (pins 0 to 31) and 0x38 (pins 32 to 53 at bits 0 to 21, bits 31:22 zero) return the synchronised inputs. A change on `pin_in` applied before edge n is returned by a read strobed at edge n+2, and not by reads strobed at edges n or n+1.
- R7: The set and clear words read as 0. Unmapped offsets (for example 0x18) and misaligned addresses read as 0, and writes to them change no state. Writes to the level words change no state.
- R8: An output latch keeps its value, and keeps driving `pin_out`, whatever the pin's function code is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| pin_in | input | 54 | Raw pin input levels |
| pin_out | output | 54 | Output latch values |
| pin_oe | output | 54 | Output enable, high for code 1 only |
| pin_func | output | 162 | 3-bit function code per pin, pin p at bits [p*3 +: 3] |

## Verification
A corrupted function code shows up on the next cycle in two places: on `pin_func`, and on `pin_oe` when it moves to or from code 1. A later read of the function word also shows it. A latch that flips on its own or misses a set or clear shows directly on `pin_out`, one cycle after the write. The bench therefore checks the pin vectors right after each write. A synchroniser stage that is too long or too short shows as level data that arrives one read early or late, so the bench reads back in three consecutive cycles after an input change.

// File: rtl/gpio_fsel_pkg.sv
package gpio_fsel_pkg;
  localparam int unsigned CODE_W        = 3;
  localparam int unsigned PINS_PER_WORD = 10;
  localparam int unsigned BUS_W         = 32;

  // word indices (byte offset / 4)
  localparam int unsigned SET_IDX = 7;   // 0x1C
  localparam int unsigned CLR_IDX = 10;  // 0x28
  localparam int unsigned LVL_IDX = 13;  // 0x34

  typedef enum logic [CODE_W-1:0] {
    FN_INPUT  = 3'd0,
    FN_OUTPUT = 3'd1,
    FN_ALT5   = 3'd2,
    FN_ALT4   = 3'd3,
    FN_ALT0   = 3'd4,
    FN_ALT1   = 3'd5,
    FN_ALT2   = 3'd6,
    FN_ALT3   = 3'd7
  } fn_code_e;
endpackage

// File: rtl/gpio_fsel_sync.sv
module gpio_fsel_sync #(
  parameter int unsigned WIDTH = 54
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_fsel_func_regs.sv
module gpio_fsel_func_regs
  import gpio_fsel_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 54,
  parameter int unsigned NUM_WORDS = (NUM_PINS + PINS_PER_WORD - 1) / PINS_PER_WORD
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_WORDS-1:0]              word_we,
  input  logic [PINS_PER_WORD*CODE_W-1:0]   wdata,
  output logic [NUM_PINS*CODE_W-1:0]        codes
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int unsigned WORD  = p / PINS_PER_WORD;
    localparam int unsigned SHIFT = (p % PINS_PER_WORD) * CODE_W;
    logic [CODE_W-1:0] code_q, code_d;

    always_comb begin
      code_d = code_q;
      if (word_we[WORD]) code_d = wdata[SHIFT +: CODE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code_q <= FN_INPUT;
      else        code_q <= code_d;
    end

    assign codes[p*CODE_W +: CODE_W] = code_q;

    a_r2_code_capture: assert property (@(posedge clk) disable iff (!rst_n)
      word_we[WORD] |=> codes[p*CODE_W +: CODE_W] == $past(wdata[SHIFT +: CODE_W]));
    a_r2_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !word_we[WORD] |=> $stable(codes[p*CODE_W +: CODE_W]));
  end
endmodule

// File: rtl/gpio_fsel_out_latch.sv
module gpio_fsel_out_latch
  import gpio_fsel_pkg::*;
#(
  parameter int unsigned NUM_PINS = 54
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PINS-1:0]        set_mask,
  input  logic [NUM_PINS-1:0]        clr_mask,
  input  logic [NUM_PINS*CODE_W-1:0] codes,
  output logic [NUM_PINS-1:0]        pin_out,
  output logic [NUM_PINS-1:0]        pin_oe
);
  logic [NUM_PINS-1:0] latch_q, latch_d;

  always_comb begin
    latch_d = (latch_q | set_mask) & ~clr_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else        latch_q <= latch_d;
  end

  assign pin_out = latch_q;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_oe
    assign pin_oe[p] = (codes[p*CODE_W +: CODE_W] == FN_OUTPUT);

    a_r3_set_high: assert property (@(posedge clk) disable iff (!rst_n)
      set_mask[p] |=> pin_out[p]);
    a_r4_clear_low: assert property (@(posedge clk) disable iff (!rst_n)
      clr_mask[p] |=> !pin_out[p]);
    a_r8_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_mask[p] && !clr_mask[p]) |=> $stable(pin_out[p]));
  end
endmodule

// File: rtl/gpio_fsel_port.sv
module gpio_fsel_port
  import gpio_fsel_pkg::*;
#(
  parameter int unsigned NUM_PINS = 54,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_sel,
  input  logic                       bus_wr,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [BUS_W-1:0]           bus_wdata,
  output logic [BUS_W-1:0]           bus_rdata,
  input  logic [NUM_PINS-1:0]        pin_in,
  output logic [NUM_PINS-1:0]        pin_out,
  output logic [NUM_PINS-1:0]        pin_oe,
  output logic [NUM_PINS*CODE_W-1:0] pin_func
);
  localparam int unsigned IDX_W     = ADDR_W - 2;
  localparam int unsigned NUM_FWORD = (NUM_PINS + PINS_PER_WORD - 1) / PINS_PER_WORD;
  localparam int unsigned NUM_BANKS = (NUM_PINS + BUS_W - 1) / BUS_W;

  logic [IDX_W-1:0] widx;
  logic             aligned, wr_hit, rd_hit;
  logic [NUM_FWORD-1:0] fword_we;
  logic [NUM_PINS-1:0]  set_mask, clr_mask, level;
  logic [BUS_W-1:0]     fword_rd [NUM_FWORD];
  logic [BUS_W-1:0]     lvl_word [NUM_BANKS];
  logic [BUS_W-1:0]     rd_mux, rdata_d, rdata_q;

  assign widx    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_hit  = bus_sel &  bus_wr & aligned;
  assign rd_hit  = bus_sel & ~bus_wr;

  // write decode
  for (genvar w = 0; w < NUM_FWORD; w++) begin : g_fwe
    assign fword_we[w] = wr_hit && (widx == IDX_W'(w));
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_masks
    assign set_mask[p] = wr_hit && (widx == IDX_W'(SET_IDX + p / BUS_W)) && bus_wdata[p % BUS_W];
    assign clr_mask[p] = wr_hit && (widx == IDX_W'(CLR_IDX + p / BUS_W)) && bus_wdata[p % BUS_W];
  end

  gpio_fsel_func_regs #(.NUM_PINS(NUM_PINS), .NUM_WORDS(NUM_FWORD)) u_func (
    .clk     (clk),
    .rst_n   (rst_n),
    .word_we (fword_we),
    .wdata   (bus_wdata[PINS_PER_WORD*CODE_W-1:0]),
    .codes   (pin_func)
  );

  gpio_fsel_out_latch #(.NUM_PINS(NUM_PINS)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_mask (set_mask),
    .clr_mask (clr_mask),
    .codes    (pin_func),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe)
  );

  gpio_fsel_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (level)
  );

  // read-side word assembly
  for (genvar w = 0; w < NUM_FWORD; w++) begin : g_fword
    for (genvar k = 0; k < PINS_PER_WORD; k++) begin : g_slot
      if (w * PINS_PER_WORD + k < NUM_PINS) begin : g_used
        assign fword_rd[w][k*CODE_W +: CODE_W] = pin_func[(w*PINS_PER_WORD+k)*CODE_W +: CODE_W];
      end else begin : g_empty
        assign fword_rd[w][k*CODE_W +: CODE_W] = '0;
      end
    end
    assign fword_rd[w][BUS_W-1:PINS_PER_WORD*CODE_W] = '0;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar j = 0; j < BUS_W; j++) begin : g_bit
      if (b * BUS_W + j < NUM_PINS) begin : g_used
        assign lvl_word[b][j] = level[b*BUS_W+j];
      end else begin : g_empty
        assign lvl_word[b][j] = 1'b0;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int w = 0; w < NUM_FWORD; w++)
      if (widx == IDX_W'(w)) rd_mux = fword_rd[w];
    for (int b = 0; b < NUM_BANKS; b++)
      if (widx == IDX_W'(LVL_IDX + b)) rd_mux = lvl_word[b];
    if (!aligned) rd_mux = '0;
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_hit) rdata_d = rd_mux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  a_r7_read_tracks_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> $stable(bus_rdata));
  a_r5_oe_one_hot_code: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_oe[0]) |-> $past(fword_we[0]));
endmodule

// File: tb/gpio_fsel_port_test.sv
module gpio_fsel_port_test;
  localparam int NP = 54;
  logic clk = 1'b0;
  logic rst_n;
  logic bus_sel, bus_wr;
  logic [7:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [NP-1:0] pin_in, pin_out, pin_oe;
  logic [NP*3-1:0] pin_func;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct { logic [31:0] exp; string tag; } rd_item_t;
  rd_item_t rd_q[$];
  logic rd_fire;

  always #2.5 clk = ~clk;

  gpio_fsel_port uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_func(pin_func)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: called at a negedge, leaves at the next negedge
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string tag);
    rd_item_t it;
    it.exp = e; it.tag = tag;
    rd_q.push_back(it);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  // monitor
  always_ff @(posedge clk) rd_fire <= bus_sel && !bus_wr;

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rd_fire && rst_n) begin
        if (rd_q.size() == 0) begin
          total++; bad++;
          $display("FAIL monitor: read data with empty queue actual=%h expected=none", bus_rdata);
        end else begin
          rd_item_t it;
          it = rd_q.pop_front();
          chk(it.tag, {32'h0, bus_rdata}, {32'h0, it.exp});
        end
      end
    end
  end

  initial begin
    #(5 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pin_out", 64'(pin_out), 64'h0);
    chk("R1 pin_oe", 64'(pin_oe), 64'h0);
    chk("R1 pin_func", 64'(pin_func[63:0] | pin_func[127:64] | 64'(pin_func[161:128])), 64'h0);
    bus_read(8'h00, 32'h0, "R1 fsel word0 after reset");
    bus_read(8'h14, 32'h0, "R1 fsel word5 after reset");

    // R2 / R5 function word layout
    bus_write(8'h00, 32'hD000_0021);   // pin0=1, pin1=4, pin9=2, top bits set
    chk("R5 oe pin0 code1", 64'(pin_oe[0]), 64'h1);
    chk("R5 oe pin1 alt0", 64'(pin_oe[1]), 64'h0);
    chk("R5 oe pin9 alt5", 64'(pin_oe[9]), 64'h0);
    chk("R5 func pin1", 64'(pin_func[5:3]), 64'h4);
    chk("R5 func pin9", 64'(pin_func[29:27]), 64'h2);
    bus_read(8'h00, 32'h1000_0021, "R2 fsel word0 readback top bits zero");
    bus_write(8'h10, 32'h0020_0000);   // pin47 code 1
    chk("R2 oe pin47", 64'(pin_oe[47]), 64'h1);
    bus_write(8'h14, 32'hFFFF_FFFF);
    chk("R2 func pin53", 64'(pin_func[161:159]), 64'h7);
    chk("R5 oe pins50-53 alt3", 64'(pin_oe[53:50]), 64'h0);
    bus_read(8'h14, 32'h0000_0FFF, "R2 fsel word5 only pins 50-53");

    // R3 set
    bus_write(8'h1C, 32'h0000_0003);
    chk("R3 set pins0-1", 64'(pin_out[3:0]), 64'h3);
    bus_write(8'h1C, 32'h0000_0000);
    chk("R3 zero set no effect", 64'(pin_out), 64'h3);
    bus_write(8'h20, 32'h0000_8000);
    chk("R3 set bank1 pin47", 64'(pin_out[47]), 64'h1);
    bus_read(8'h1C, 32'h0, "R7 set word reads zero");
    bus_read(8'h2C, 32'h0, "R7 clear word reads zero");

    // R4 clear
    bus_write(8'h28, 32'h0000_0001);
    chk("R4 clear pin0", 64'(pin_out[1:0]), 64'h2);
    bus_write(8'h2C, 32'h0000_0000);
    chk("R4 zero clear no effect", 64'(pin_out[47]), 64'h1);
    bus_write(8'h2C, 32'h0000_8000);
    chk("R4 clear bank1 pin47", 64'(pin_out[47]), 64'h0);

    // R8 latch holds regardless of code (pin1 is alternate 0)
    chk("R8 pin1 latch under alt code", 64'(pin_out[1]), 64'h1);
    bus_write(8'h00, 32'h0000_0000);
    chk("R5 oe pin0 back to input", 64'(pin_oe[0]), 64'h0);
    chk("R8 pin1 latch after code change", 64'(pin_out[1]), 64'h1);

    // R7 unmapped / misaligned / read-only
    bus_write(8'h18, 32'hFFFF_FFFF);
    bus_write(8'h01, 32'hFFFF_FFFF);
    bus_write(8'h34, 32'hFFFF_FFFF);
    chk("R7 ignored writes leave latches", 64'(pin_out), 64'h2);
    bus_read(8'h18, 32'h0, "R7 unmapped reads zero");
    bus_read(8'h01, 32'h0, "R7 misaligned reads zero");
    bus_read(8'h00, 32'h0, "R7 fsel word0 untouched");
    bus_read(8'h34, 32'h0, "R7 level not writable");

    // R6 level with synchroniser latency
    pin_in = {22'h3C0F1, 32'hDEAD_BEEF};
    bus_read(8'h34, 32'h0, "R6 level edge n old");
    bus_read(8'h34, 32'h0, "R6 level edge n+1 old");
    bus_read(8'h34, 32'hDEAD_BEEF, "R6 level edge n+2 new");
    bus_read(8'h38, 32'h0003_C0F1, "R6 bank1 upper bits zero");
    pin_in = '1;
    repeat (3) @(negedge clk);
    bus_read(8'h38, 32'h003F_FFFF, "R6 bank1 all ones masked");

    repeat (4) @(negedge clk);
    if (rd_q.size() != 0) begin
      total++; bad++;
      $display("FAIL monitor: reads left unchecked actual=%0d expected=0", rd_q.size());
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule